// File: doc/BRIEF.md
# Bufferless Hybrid Circuit/Packet Mesh Router

This block is one node of a two-dimensional mesh. It has five bidirectional ports (north, east, south, west and the local attachment point) and holds no flit queues. Each port has one data lane that carries two things at different times: routing packets, and the payload words of a circuit that has already been set up. A routing packet chooses its output by dimension-order routing. A parameter selects whether X is resolved before Y, or Y before X. When several inputs want the same free output in one cycle, a round-robin arbiter picks one of them.

A routing packet comes in one of two kinds. A circuit-setup packet claims its output and keeps it: every later word on that input goes straight to the same output without arbitration, and a 4-bit reverse control field runs back along the path. This lasts until a word arrives with the unlock flag set. That word is forwarded, so the release travels on to the next hop, and then the pairing is freed. A data-carrying packet moves by plain packet switching. It holds its output only for the cycle in which it crosses. Each hop takes two cycles: routing and allocation in the first, traversal through the output register in the second.

Flow control uses one congestion bit per link in each direction. A router raises this bit towards its upstream neighbour while it cannot take the word that neighbour is offering. A raised bit from a downstream neighbour keeps new grants off that output and holds the word already in the output register.

Top module: `hybrid_mesh_router`

## Requirements
- R1: After reset no output is valid, no input is stalled, and every reverse control output is zero.
- R2: A routing packet carries its kind in bits [1:0], its destination X in bits [2+XW-1:2] and its destination Y in the next YW bits. Port indices are north 0, east 1, south 2, west 3, local 4. North means larger Y and east means larger X. In XY mode a differing X is resolved first; a destination equal to the router's own coordinates goes to local.
- R3: In YX mode a differing Y is resolved before X, and the same port indices and field positions apply.
- R4: A packet of kind 2'b10 (with data) that is accepted at a clock edge appears on its output, unchanged, after that edge, and it sets up no lock.
- R5: When several unlocked inputs request the same free output, exactly one is granted in round-robin order, starting from index 0 after reset. Each loser sees its stall bit high.
- R6: A packet of kind 2'b01 (circuit setup) is forwarded and locks its input to the chosen output. Later words on that input pass to the same output whatever their low bits are, and any other input that requests that output is stalled.
- R7: While an input is locked, its reverse control output equals the reverse control input of its locked output. An unlocked input drives zero.
- R8: Forward control bit 0 marks a valid word and bit 1 marks unlock. On a locked input, a valid word with unlock set is forwarded with both bits intact, and the output is free for arbitration in the next cycle.
- R9: While the downstream congestion bit of an output is high, that output grants nothing, the requesting input stays stalled, and a word already in the output register stays valid and unchanged.
- R10: On an unlocked input, a valid word of kind 2'b00 or 2'b11 is dropped: it reaches no output and does not stall the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dat | input | 5×DW | Incoming data lane per port |
| rx_ctl | input | 5×2 | Incoming forward control per port: [0] valid, [1] unlock |
| rx_stat | output | 5 | Stall/congestion bit towards each upstream neighbour |
| rx_rev | output | 5×4 | Reverse control towards each upstream neighbour |
| tx_dat | output | 5×DW | Outgoing data lane per port (registered) |
| tx_ctl | output | 5×2 | Outgoing forward control per port (registered) |
| tx_stat | input | 5 | Congestion bit from each downstream neighbour |
| tx_rev | input | 5×4 | Reverse control from each downstream neighbour |

## Verification
A lock entry that is stuck or points to the wrong output shows up within one cycle. Another input that requests that output keeps its stall bit raised, reverse control leaks onto an input that should read zero, or payload words leave on the wrong lane. A damaged round-robin pointer changes the order of winners by the second contended cycle. A routing or field-slice fault sends a packet to the wrong lane one edge after it is accepted, so the sweep over every destination and every input catches it. A fault in the hold logic shows as a word that vanishes or changes while the downstream congestion bit is high.

// File: rtl/hr_pkg.sv
`timescale 1ns/1ps
package hr_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  localparam logic [2:0] P_N = 3'd0;
  localparam logic [2:0] P_E = 3'd1;
  localparam logic [2:0] P_S = 3'd2;
  localparam logic [2:0] P_W = 3'd3;
  localparam logic [2:0] P_L = 3'd4;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_SETUP = 2'b01,
    K_DATA  = 2'b10,
    K_RSVD  = 2'b11
  } kind_e;
endpackage

// File: rtl/hr_route_calc.sv
`timescale 1ns/1ps
module hr_route_calc
  import hr_pkg::*;
#(
  parameter int XW       = 2,
  parameter int YW       = 2,
  parameter int MY_X     = 1,
  parameter int MY_Y     = 1,
  parameter int YX_FIRST = 0
) (
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic [2:0]    dir
);
  localparam logic [XW-1:0] HOME_X = XW'(MY_X);
  localparam logic [YW-1:0] HOME_Y = YW'(MY_Y);

  logic x_up, x_dn, y_up, y_dn;
  assign x_up = dst_x > HOME_X;
  assign x_dn = dst_x < HOME_X;
  assign y_up = dst_y > HOME_Y;
  assign y_dn = dst_y < HOME_Y;

  generate
    if (YX_FIRST != 0) begin : g_yx
      always_comb begin
        if (y_up)      dir = P_N;
        else if (y_dn) dir = P_S;
        else if (x_up) dir = P_E;
        else if (x_dn) dir = P_W;
        else           dir = P_L;
      end
    end else begin : g_xy
      always_comb begin
        if (x_up)      dir = P_E;
        else if (x_dn) dir = P_W;
        else if (y_up) dir = P_N;
        else if (y_dn) dir = P_S;
        else           dir = P_L;
      end
    end
  endgenerate
endmodule

// File: rtl/hr_rr_arb.sv
`timescale 1ns/1ps
module hr_rr_arb #(
  parameter int N = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic          found;

  always_comb begin
    int idx;
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (!found && en && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (found) begin
      if (win == IW'(N - 1)) ptr_d = '0;
      else                   ptr_d = win + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (found) ptr_q <= ptr_d;
  end

  // R5: never more than one winner per output
  a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/hr_link_reg.sv
`timescale 1ns/1ps
module hr_link_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] nxt_dat,
  input  logic [1:0]    nxt_ctl,
  input  logic          nb_stat,
  output logic [DW-1:0] q_dat,
  output logic [1:0]    q_ctl
);
  logic [1:0] ctl_d;

  always_comb begin
    ctl_d = q_ctl;
    if (load)                     ctl_d = nxt_ctl;
    else if (!(q_ctl[0] && nb_stat)) ctl_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_ctl <= 2'b00;
    else        q_ctl <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_dat <= '0;
    else if (load) q_dat <= nxt_dat;
  end

  // R9: a word held against downstream congestion stays put
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctl[0] && nb_stat) |=> (q_ctl[0] && $stable(q_dat)));
endmodule

// File: rtl/hybrid_mesh_router.sv
`timescale 1ns/1ps
module hybrid_mesh_router
  import hr_pkg::*;
#(
  parameter int DW       = 16,
  parameter int XW       = 2,
  parameter int YW       = 2,
  parameter int MY_X     = 1,
  parameter int MY_Y     = 1,
  parameter int YX_FIRST = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0][DW-1:0]   rx_dat,
  input  logic [NPORT-1:0][1:0]      rx_ctl,
  output logic [NPORT-1:0]           rx_stat,
  output logic [NPORT-1:0][3:0]      rx_rev,
  output logic [NPORT-1:0][DW-1:0]   tx_dat,
  output logic [NPORT-1:0][1:0]      tx_ctl,
  input  logic [NPORT-1:0]           tx_stat,
  input  logic [NPORT-1:0][3:0]      tx_rev
);
  localparam int NP  = NPORT;
  localparam int XLO = 2;
  localparam int YLO = XLO + XW;

  logic [PW-1:0]  dir      [NP];
  kind_e          kind     [NP];
  logic [NP-1:0]  is_pkt;
  logic [NP-1:0]  lock_vld_q, lock_vld_d;
  logic [PW-1:0]  lock_dst_q [NP];
  logic [PW-1:0]  lock_dst_d [NP];
  logic [NP-1:0]  out_locked;
  logic [PW-1:0]  owner    [NP];
  logic [NP-1:0]  own_vec  [NP];
  logic [NP-1:0]  req_m    [NP];
  logic [NP-1:0]  gnt_m    [NP];
  logic [PW-1:0]  gidx     [NP];
  logic [NP-1:0]  arb_en;
  logic [NP-1:0]  free;
  logic [NP-1:0]  in_gnt;
  logic [NP-1:0]  load;
  logic [PW-1:0]  sel      [NP];

  // per-input decode and route compute
  generate
    for (genvar p = 0; p < NP; p++) begin : g_in
      assign kind[p]   = kind_e'(rx_dat[p][1:0]);
      assign is_pkt[p] = (kind[p] == K_SETUP) || (kind[p] == K_DATA);
      hr_route_calc #(
        .XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y), .YX_FIRST(YX_FIRST)
      ) u_route (
        .dst_x (rx_dat[p][YLO-1:XLO]),
        .dst_y (rx_dat[p][YLO+YW-1:YLO]),
        .dir   (dir[p])
      );
    end
  endgenerate

  // lock ownership per output
  always_comb begin
    for (int q = 0; q < NP; q++) begin
      out_locked[q] = 1'b0;
      owner[q]      = '0;
      own_vec[q]    = '0;
      for (int p = 0; p < NP; p++) begin
        if (lock_vld_q[p] && lock_dst_q[p] == PW'(q)) begin
          out_locked[q] = 1'b1;
          owner[q]      = PW'(p);
          own_vec[q][p] = 1'b1;
        end
      end
    end
  end

  // request matrix, output availability
  always_comb begin
    for (int q = 0; q < NP; q++) begin
      free[q]   = !tx_ctl[q][0] || !tx_stat[q];
      arb_en[q] = !out_locked[q] && !tx_stat[q];
      for (int p = 0; p < NP; p++) begin
        req_m[q][p] = rx_ctl[p][0] && !lock_vld_q[p] && is_pkt[p] &&
                      (dir[p] == PW'(q));
      end
    end
  end

  // arbiter and output register per output
  generate
    for (genvar q = 0; q < NP; q++) begin : g_out
      hr_rr_arb #(.N(NP)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arb_en[q]),
        .req   (req_m[q]),
        .gnt   (gnt_m[q]),
        .win   (gidx[q])
      );

      always_comb begin
        if (out_locked[q]) begin
          sel[q]  = owner[q];
          load[q] = rx_ctl[owner[q]][0] && free[q];
        end else begin
          sel[q]  = gidx[q];
          load[q] = |gnt_m[q];
        end
      end

      hr_link_reg #(.DW(DW)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load[q]),
        .nxt_dat (rx_dat[sel[q]]),
        .nxt_ctl (rx_ctl[sel[q]]),
        .nb_stat (tx_stat[q]),
        .q_dat   (tx_dat[q]),
        .q_ctl   (tx_ctl[q])
      );

      // R6: an output is never locked to two inputs
      a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_vec[q]));
    end
  endgenerate

  // per-input grant, stall and reverse control
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_gnt[p] = 1'b0;
      for (int q = 0; q < NP; q++) in_gnt[p] = in_gnt[p] | gnt_m[q][p];
      if (lock_vld_q[p]) begin
        rx_stat[p] = rx_ctl[p][0] && !free[lock_dst_q[p]];
        rx_rev[p]  = tx_rev[lock_dst_q[p]];
      end else begin
        rx_stat[p] = rx_ctl[p][0] && is_pkt[p] && !in_gnt[p];
        rx_rev[p]  = 4'h0;
      end
    end
  end

  // lock table next state
  always_comb begin
    lock_vld_d = lock_vld_q;
    for (int p = 0; p < NP; p++) begin
      lock_dst_d[p] = lock_dst_q[p];
      if (!lock_vld_q[p] && in_gnt[p] && kind[p] == K_SETUP) begin
        lock_vld_d[p] = 1'b1;
        lock_dst_d[p] = dir[p];
      end else if (lock_vld_q[p] && rx_ctl[p] == 2'b11 && free[lock_dst_q[p]]) begin
        lock_vld_d[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_vld_q <= '0;
      for (int p = 0; p < NP; p++) lock_dst_q[p] <= '0;
    end else begin
      lock_vld_q <= lock_vld_d;
      for (int p = 0; p < NP; p++) lock_dst_q[p] <= lock_dst_d[p];
    end
  end

  generate
    for (genvar p = 0; p < NP; p++) begin : g_chk
      // R8: an accepted unlock word frees the pairing
      a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vld_q[p] && rx_ctl[p] == 2'b11 && !rx_stat[p]) |=> !lock_vld_q[p]);
      // R4: a data-carrying packet leaves no lock behind
      a_r4_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_vld_q[p] && in_gnt[p] && kind[p] == K_DATA) |=> !lock_vld_q[p]);
    end
  endgenerate
endmodule

// File: tb/hybrid_mesh_router_test.sv
`timescale 1ns/1ps
module hybrid_mesh_router_test;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [4:0][15:0] rx_dat, tx_dat, y_rx_dat, y_tx_dat;
  logic [4:0][1:0]  rx_ctl, tx_ctl, y_rx_ctl, y_tx_ctl;
  logic [4:0]       rx_stat, tx_stat, y_rx_stat, y_tx_stat;
  logic [4:0][3:0]  rx_rev, tx_rev, y_rx_rev, y_tx_rev;

  int total = 0;
  int bad   = 0;

  hybrid_mesh_router #(.DW(16), .XW(2), .YW(2), .MY_X(1), .MY_Y(1), .YX_FIRST(0)) uut (
    .clk(clk), .rst_n(rst_n), .rx_dat(rx_dat), .rx_ctl(rx_ctl), .rx_stat(rx_stat),
    .rx_rev(rx_rev), .tx_dat(tx_dat), .tx_ctl(tx_ctl), .tx_stat(tx_stat), .tx_rev(tx_rev));

  hybrid_mesh_router #(.DW(16), .XW(2), .YW(2), .MY_X(1), .MY_Y(1), .YX_FIRST(1)) uut_yx (
    .clk(clk), .rst_n(rst_n), .rx_dat(y_rx_dat), .rx_ctl(y_rx_ctl), .rx_stat(y_rx_stat),
    .rx_rev(y_rx_rev), .tx_dat(y_tx_dat), .tx_ctl(y_tx_ctl), .tx_stat(y_tx_stat), .tx_rev(y_tx_rev));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkpkt(input logic [1:0] k, input int x, input int y, input int tag);
    return {10'(tag), 2'(y), 2'(x), k};
  endfunction

  // N=0 E=1 S=2 W=3 L=4, home (1,1)
  function automatic int exp_dir(input int x, input int y, input bit yx);
    if (!yx) begin
      if (x > 1) return 1;
      if (x < 1) return 3;
      if (y > 1) return 0;
      if (y < 1) return 2;
      return 4;
    end
    if (y > 1) return 0;
    if (y < 1) return 2;
    if (x > 1) return 1;
    if (x < 1) return 3;
    return 4;
  endfunction

  function automatic logic [15:0] nvalid(input logic [4:0][1:0] c);
    logic [15:0] n = 0;
    for (int i = 0; i < 5; i++) n = n + 16'(c[i][0]);
    return n;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    rx_dat = '0; rx_ctl = '0; tx_stat = '0; tx_rev = '0;
    y_rx_dat = '0; y_rx_ctl = '0; y_tx_stat = '0; y_tx_rev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pk, pk_s, pk_e, pk_w;
    int q;
    do_reset();

    // R1: reset state
    check("R1 tx valid count", 32'(nvalid(tx_ctl)), 32'd0);
    check("R1 rx_stat", 32'(rx_stat), 32'd0);
    check("R1 rx_rev", 32'(rx_rev), 32'd0);

    // R2, R4: XY sweep over every input and destination
    for (int p = 0; p < 5; p++) begin
      for (int x = 0; x < 4; x++) begin
        for (int y = 0; y < 4; y++) begin
          pk = mkpkt(2'b10, x, y, p * 16 + x * 4 + y);
          q = exp_dir(x, y, 1'b0);
          rx_dat[p] = pk; rx_ctl[p] = 2'b01;
          @(negedge clk);
          rx_ctl[p] = 2'b00;
          check("R2 xy route", {nvalid(tx_ctl), tx_dat[q]}, {16'd1, pk});
          @(negedge clk);
          check("R4 output freed", 32'(nvalid(tx_ctl)), 32'd0);
        end
      end
    end

    // R3: YX sweep
    for (int p = 0; p < 5; p++) begin
      for (int x = 0; x < 4; x++) begin
        for (int y = 0; y < 4; y++) begin
          pk = mkpkt(2'b10, x, y, 100 + x * 4 + y);
          q = exp_dir(x, y, 1'b1);
          y_rx_dat[p] = pk; y_rx_ctl[p] = 2'b01;
          @(negedge clk);
          y_rx_ctl[p] = 2'b00;
          check("R3 yx route", {nvalid(y_tx_ctl), y_tx_dat[q]}, {16'd1, pk});
          @(negedge clk);
        end
      end
    end

    // R5: round-robin between east(1) and west(3) towards local
    do_reset();
    begin
      int ecount = 0, wcount = 0;
      for (int r = 0; r < 4; r++) begin
        pk_e = mkpkt(2'b10, 1, 1, 200 + ecount);
        pk_w = mkpkt(2'b10, 1, 1, 300 + wcount);
        rx_dat[1] = pk_e; rx_ctl[1] = 2'b01;
        rx_dat[3] = pk_w; rx_ctl[3] = 2'b01;
        #1;
        if (r % 2 == 0) check("R5 loser west stalled", 32'(rx_stat), 32'b01000);
        else            check("R5 loser east stalled", 32'(rx_stat), 32'b00010);
        @(negedge clk);
        if (r % 2 == 0) begin
          check("R5 east wins", {nvalid(tx_ctl), tx_dat[4]}, {16'd1, pk_e});
          ecount++;
        end else begin
          check("R5 west wins", {nvalid(tx_ctl), tx_dat[4]}, {16'd1, pk_w});
          wcount++;
        end
      end
      rx_ctl = '0;
      @(negedge clk);
    end

    // R6, R7, R8: circuit from west(3) to east(1)
    do_reset();
    pk = mkpkt(2'b01, 2, 1, 400);
    rx_dat[3] = pk; rx_ctl[3] = 2'b01;
    @(negedge clk);
    check("R6 setup forwarded", {14'd0, tx_ctl[1], tx_dat[1]}, {14'd0, 2'b01, pk});
    pk_s = mkpkt(2'b10, 2, 1, 401);
    rx_dat[2] = pk_s; rx_ctl[2] = 2'b01;
    rx_dat[3] = 16'h1230; rx_ctl[3] = 2'b01;
    tx_rev[1] = 4'hA;
    #1;
    check("R6 competing input stalled", 32'(rx_stat), 32'b00100);
    check("R7 reverse on locked input", 32'(rx_rev[3]), 32'hA);
    check("R7 reverse zero when unlocked", 32'(rx_rev[2]), 32'h0);
    @(negedge clk);
    check("R6 payload passes", {14'd0, tx_ctl[1], tx_dat[1]}, {14'd0, 2'b01, 16'h1230});
    rx_dat[3] = 16'h4567; rx_ctl[3] = 2'b11;
    #1;
    check("R6 still stalled during unlock word", 32'(rx_stat[2]), 32'd1);
    @(negedge clk);
    check("R8 unlock word forwarded", {14'd0, tx_ctl[1], tx_dat[1]}, {14'd0, 2'b11, 16'h4567});
    rx_ctl[3] = 2'b00;
    #1;
    check("R8 waiting input granted", 32'(rx_stat[2]), 32'd0);
    check("R7 reverse cleared after unlock", 32'(rx_rev[3]), 32'h0);
    @(negedge clk);
    check("R8 freed output carries other packet", {nvalid(tx_ctl), tx_dat[1]}, {16'd1, pk_s});
    rx_ctl = '0; tx_rev = '0;
    @(negedge clk);

    // R9: congestion on north(0) output
    do_reset();
    tx_stat[0] = 1'b1;
    pk = mkpkt(2'b10, 1, 2, 500);
    rx_dat[4] = pk; rx_ctl[4] = 2'b01;
    #1;
    check("R9 input stalled by congestion", 32'(rx_stat[4]), 32'd1);
    @(negedge clk);
    check("R9 no grant while congested", 32'(nvalid(tx_ctl)), 32'd0);
    tx_stat[0] = 1'b0;
    #1;
    check("R9 stall drops", 32'(rx_stat[4]), 32'd0);
    @(negedge clk);
    check("R9 packet leaves", {nvalid(tx_ctl), tx_dat[0]}, {16'd1, pk});
    rx_ctl[4] = 2'b00;
    tx_stat[0] = 1'b1;
    @(negedge clk);
    check("R9 word held", {nvalid(tx_ctl), tx_dat[0]}, {16'd1, pk});
    tx_stat[0] = 1'b0;
    @(negedge clk);
    check("R9 released word gone", 32'(nvalid(tx_ctl)), 32'd0);

    // R10: reserved kinds dropped
    for (int k = 0; k < 4; k = k + 3) begin
      pk = mkpkt(2'(k), 2, 1, 600 + k);
      rx_dat[4] = pk; rx_ctl[4] = 2'b01;
      #1;
      check("R10 no stall on dropped kind", 32'(rx_stat), 32'd0);
      @(negedge clk);
      rx_ctl[4] = 2'b00;
      check("R10 nothing forwarded", 32'(nvalid(tx_ctl)), 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule